// File: doc/BRIEF.md
# Multi-Width Arithmetic Flag Generator

This combinational unit takes two 32-bit operands, an operation code and an operand size. It returns the result masked to that size and six status flags: carry, parity, auxiliary carry, zero, sign and overflow. It sits beside an integer execution datapath and supplies the next flag values. The surrounding core decides whether to write them into its own flag state.

Carry, sign and overflow are taken at the most significant bit of the selected width, which is bit 7, 15 or 31. Auxiliary carry always comes from the boundary between bits 3 and 4. Parity always comes from the low byte of the result. Both ignore the width.

Operations are add, add with incoming carry, subtract, subtract with incoming borrow, and three bitwise operations. The two carry-consuming operations feed the incoming bit into both the full carry chain and the low-nibble auxiliary carry.

Top module: `arithFlagUnit`

## Requirements
- R1: `result` equals the operation's outcome with every bit above the selected width forced to 0. Size code 0 selects 8 bits, 1 selects 16 bits and 2 selects 32 bits.
- R2: For add operations (codes 0 and 1), `flagCarry` is 1 when there is a carry out of the top bit of the selected width. For subtract operations (codes 2 and 3), it is 1 when the subtraction borrows at that bit.
- R3: For arithmetic operations, `flagOverflow` is 1 exactly when the signed result does not fit in the selected width. This is the same as the carry into the top bit differing from the carry out of it.
- R4: For arithmetic operations, `flagAux` is 1 on a carry out of bit 3 when adding, or a borrow into bit 3 when subtracting, at every width. Otherwise it is 0.
- R5: `flagParity` is 1 when bits 7..0 of `result` hold an even number of ones, and 0 otherwise, at every width.
- R6: `flagZero` is 1 exactly when the masked `result` is all zeros.
- R7: `flagSign` equals bit 7, 15 or 31 of `result` for the 8-, 16- or 32-bit size.
- R8: The logical operations clear `flagCarry`, `flagOverflow` and `flagAux`. Their codes are 4 for AND, 5 for OR and 6 for XOR.
- R9: Code 1 computes opA + opB + carryIn. Code 3 computes opA - opB - carryIn. In both cases the incoming bit takes part in the carry/borrow and in the auxiliary carry. Codes 0 and 2 ignore `carryIn`.
- R10: Size code 3 behaves exactly like size code 2 (32 bits).
- R11: Operation code 7 behaves exactly like code 4 (bitwise AND).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand (minuend for subtraction) |
| opB | input | 32 | Second operand (subtrahend for subtraction) |
| opSel | input | 3 | Operation code: 0 add, 1 add with carry, 2 sub, 3 sub with borrow, 4 AND, 5 OR, 6 XOR, 7 AND |
| opSize | input | 2 | Width code: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits |
| carryIn | input | 1 | Incoming carry or borrow for codes 1 and 3 |
| result | output | 32 | Result masked to the selected width |
| flagCarry | output | 1 | Carry or borrow at the top bit of the width |
| flagParity | output | 1 | Even parity of the low result byte |
| flagAux | output | 1 | Carry or borrow at the bit-3 boundary |
| flagZero | output | 1 | Masked result is zero |
| flagSign | output | 1 | Top bit of the masked result |
| flagOverflow | output | 1 | Signed overflow at the selected width |

## Verification
The embedded checks assume every input bit is a known 0 or 1 whenever the outputs are read. Under that assumption, the flag relations they test hold for any mix of code and width. The bench meets this by driving every input in full after each active edge and reading outputs half a period later, so the block has settled. The stimulus walks all eight operation codes against all four size codes. It uses directed operands at the carry, borrow and sign edges of each width, followed by a pseudo-random stream.

// File: rtl/flagPkg.sv
package flagPkg;
  localparam int WORD_W   = 32;
  localparam int HALF_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int NIBBLE_W = 4;
  localparam int SIZE_N   = 3;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
    OP_AND = 3'd4, OP_OR  = 3'd5, OP_XOR = 3'd6, OP_ALT = 3'd7
  } opCode_e;

  typedef enum logic [1:0] {LK_AND = 2'd0, LK_OR = 2'd1, LK_XOR = 2'd2} logicKind_e;

  typedef struct packed {
    logic              subtract;
    logic              takeCarry;
    logic              logical;
    logicKind_e        logicKind;
    logic [SIZE_N-1:0] sizeHot;  // bit0 byte, bit1 half, bit2 word
  } ctrlStrobes_t;

  typedef struct packed {
    logic carry;
    logic parity;
    logic aux;
    logic zero;
    logic sign;
    logic overflow;
  } flagSet_t;
endpackage

// File: rtl/flagCtrl.sv
module flagCtrl
  import flagPkg::*;
(
  input  logic [2:0]   opSel,
  input  logic [1:0]   opSize,
  output ctrlStrobes_t strobes
);
  opCode_e opCode;

  always_comb begin
    opCode            = opCode_e'(opSel);
    strobes.subtract  = 1'b0;
    strobes.takeCarry = 1'b0;
    strobes.logical   = 1'b0;
    strobes.logicKind = LK_AND;
    unique case (opCode)
      OP_ADD: ;
      OP_ADC: strobes.takeCarry = 1'b1;
      OP_SUB: strobes.subtract  = 1'b1;
      OP_SBB: begin
        strobes.subtract  = 1'b1;
        strobes.takeCarry = 1'b1;
      end
      OP_OR:  begin strobes.logical = 1'b1; strobes.logicKind = LK_OR;  end
      OP_XOR: begin strobes.logical = 1'b1; strobes.logicKind = LK_XOR; end
      default: strobes.logical = 1'b1;  // AND and its alias
    endcase
  end

  always_comb begin
    unique case (opSize)
      2'd0:    strobes.sizeHot = 3'b001;
      2'd1:    strobes.sizeHot = 3'b010;
      default: strobes.sizeHot = 3'b100;
    endcase
  end

  always_comb begin
    assert_size_onehot_R10: assert ($onehot(strobes.sizeHot))
      else $error("size decode not one-hot");
    // R11: code 7 must decode as plain AND
    assert_alias_and_R11: assert (!(opSel == 3'd7) ||
                                  (strobes.logical && strobes.logicKind == LK_AND && !strobes.subtract))
      else $error("code 7 not decoded as AND");
  end
endmodule

// File: rtl/flagDatapath.sv
module flagDatapath
  import flagPkg::*;
(
  input  logic [WORD_W-1:0] aIn,
  input  logic [WORD_W-1:0] bIn,
  input  logic              carryIn,
  input  ctrlStrobes_t      strobes,
  output logic [WORD_W-1:0] resOut,
  output flagSet_t          flags
);
  logic [WORD_W-1:0] bEff;
  logic              cinEff;
  logic [WORD_W:0]   sumWide;
  logic [WORD_W-1:0] logicRes;
  logic [WORD_W-1:0] rawRes;
  logic [WORD_W-1:0] sizeMask;
  logic              topCarryOut;
  logic              signCarryIn;
  logic              nibbleCarry;

  function automatic logic carryInto(input int pos, input logic [WORD_W-1:0] a,
                                     input logic [WORD_W-1:0] b, input logic [WORD_W:0] s);
    return a[pos] ^ b[pos] ^ s[pos];
  endfunction

  always_comb begin
    bEff    = strobes.subtract ? ~bIn : bIn;
    cinEff  = strobes.subtract ^ (strobes.takeCarry & carryIn);
    sumWide = {1'b0, aIn} + {1'b0, bEff} + {{WORD_W{1'b0}}, cinEff};
    nibbleCarry = carryInto(NIBBLE_W, aIn, bEff, sumWide);
  end

  always_comb begin
    unique case (strobes.logicKind)
      LK_OR:   logicRes = aIn | bIn;
      LK_XOR:  logicRes = aIn ^ bIn;
      default: logicRes = aIn & bIn;
    endcase
    rawRes = strobes.logical ? logicRes : sumWide[WORD_W-1:0];
  end

  always_comb begin
    sizeMask    = {WORD_W{1'b1}};
    topCarryOut = sumWide[WORD_W];
    signCarryIn = carryInto(WORD_W-1, aIn, bEff, sumWide);
    if (strobes.sizeHot[0]) begin
      sizeMask    = {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
      topCarryOut = carryInto(BYTE_W, aIn, bEff, sumWide);
      signCarryIn = carryInto(BYTE_W-1, aIn, bEff, sumWide);
    end else if (strobes.sizeHot[1]) begin
      sizeMask    = {{(WORD_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
      topCarryOut = carryInto(HALF_W, aIn, bEff, sumWide);
      signCarryIn = carryInto(HALF_W-1, aIn, bEff, sumWide);
    end
  end

  always_comb begin
    resOut         = rawRes & sizeMask;
    flags.carry    = !strobes.logical && (topCarryOut ^ strobes.subtract);
    flags.overflow = !strobes.logical && (topCarryOut ^ signCarryIn);
    flags.aux      = !strobes.logical && (nibbleCarry ^ strobes.subtract);
    flags.parity   = ~^resOut[BYTE_W-1:0];
    flags.zero     = (resOut == '0);
    flags.sign     = strobes.sizeHot[0] ? resOut[BYTE_W-1] :
                     strobes.sizeHot[1] ? resOut[HALF_W-1] : resOut[WORD_W-1];
  end
endmodule

// File: rtl/arithFlagUnit.sv
module arithFlagUnit
  import flagPkg::*;
(
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [2:0]  opSel,
  input  logic [1:0]  opSize,
  input  logic        carryIn,
  output logic [31:0] result,
  output logic        flagCarry,
  output logic        flagParity,
  output logic        flagAux,
  output logic        flagZero,
  output logic        flagSign,
  output logic        flagOverflow
);
  ctrlStrobes_t strobes;
  flagSet_t     flags;

  flagCtrl ctrl_i (.opSel(opSel), .opSize(opSize), .strobes(strobes));

  flagDatapath dp_i (
    .aIn(opA), .bIn(opB), .carryIn(carryIn), .strobes(strobes),
    .resOut(result), .flags(flags)
  );

  assign flagCarry    = flags.carry;
  assign flagParity   = flags.parity;
  assign flagAux      = flags.aux;
  assign flagZero     = flags.zero;
  assign flagSign     = flags.sign;
  assign flagOverflow = flags.overflow;

  always_comb begin
    assert_mask_upper_R1: assert (opSize[1] || (opSize[0] ? result[31:16] == '0 : result[31:8] == '0))
      else $error("bits above width not cleared");
    assert_logic_clear_R8: assert (!opSel[2] || (!flagCarry && !flagOverflow && !flagAux))
      else $error("logical op left arithmetic flag set");
    assert_parity_low_R5: assert (flagParity == ($countones(result[7:0]) % 2 == 0))
      else $error("parity mismatch on low byte");
    assert_zero_match_R6: assert (flagZero == (result == 32'd0))
      else $error("zero flag mismatch");
    assert_sign_top_R7: assert (flagSign == (opSize == 2'd0 ? result[7] :
                                             opSize == 2'd1 ? result[15] : result[31]))
      else $error("sign flag mismatch");
  end
endmodule

// File: tb/arithFlagUnit_tb_top.sv
module arithFlagUnit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] opA = '0, opB = '0;
  logic [2:0]  opSel = '0;
  logic [1:0]  opSize = '0;
  logic        carryIn = 1'b0;
  logic [31:0] result;
  logic        flagCarry, flagParity, flagAux, flagZero, flagSign, flagOverflow;

  int checkCount = 0;
  int failCount  = 0;
  int cycleCount = 0;
  logic [31:0] rngState = 32'h1234_5678;

  arithFlagUnit dut_i (
    .opA(opA), .opB(opB), .opSel(opSel), .opSize(opSize), .carryIn(carryIn),
    .result(result), .flagCarry(flagCarry), .flagParity(flagParity), .flagAux(flagAux),
    .flagZero(flagZero), .flagSign(flagSign), .flagOverflow(flagOverflow)
  );

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input string tag, input longint actual, input longint expected);
    checkCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s op=%0d size=%0d a=%h b=%h cin=%0b actual=%h expected=%h",
               tag, opSel, opSize, opA, opB, carryIn, actual, expected);
    end
  endtask

  // Behavioural reference evaluated on the currently applied inputs
  task automatic compareNow(input string extra);
    int     w;
    longint modv, am, bm, sa, sb, c, tot, st, lo;
    longint expRes;
    logic   eC, eA, eO, eP, eZ, eS;
    int     ones;
    string  arTag, lgTag;
    w    = (opSize == 2'd0) ? 8 : (opSize == 2'd1) ? 16 : 32;
    modv = longint'(1) << w;
    am   = longint'(opA) & (modv - 1);
    bm   = longint'(opB) & (modv - 1);
    sa   = (am >= modv / 2) ? am - modv : am;
    sb   = (bm >= modv / 2) ? bm - modv : bm;
    c    = ((opSel == 3'd1) || (opSel == 3'd3)) ? longint'(carryIn) : 0;
    eC = 0; eA = 0; eO = 0;
    case (opSel)
      3'd0, 3'd1: begin
        tot = am + bm + c; expRes = tot & (modv - 1); eC = (tot >= modv);
        st = sa + sb + c;  eO = (st >= modv / 2) || (st < -(modv / 2));
        lo = (am % 16) + (bm % 16) + c; eA = (lo > 15);
      end
      3'd2, 3'd3: begin
        tot = am - bm - c; expRes = tot & (modv - 1); eC = (tot < 0);
        st = sa - sb - c;  eO = (st >= modv / 2) || (st < -(modv / 2));
        lo = (am % 16) - (bm % 16) - c; eA = (lo < 0);
      end
      3'd5:    expRes = am | bm;
      3'd6:    expRes = am ^ bm;
      default: expRes = am & bm;
    endcase
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(expRes[i]);
    eP = (ones % 2 == 0);
    eZ = (expRes == 0);
    eS = expRes[w-1];
    arTag = (c != 0 || opSel == 3'd1 || opSel == 3'd3) ? "R9" : "";
    lgTag = opSel[2] ? "R8" : "";
    check({"R1 result ", extra}, longint'(result), expRes);
    check({"R2 carry ", arTag, lgTag, " ", extra}, longint'(flagCarry), longint'(eC));
    check({"R3 overflow ", lgTag, " ", extra}, longint'(flagOverflow), longint'(eO));
    check({"R4 aux ", arTag, lgTag, " ", extra}, longint'(flagAux), longint'(eA));
    check({"R5 parity ", extra}, longint'(flagParity), longint'(eP));
    check({"R6 zero ", extra}, longint'(flagZero), longint'(eZ));
    check({"R7 sign ", extra}, longint'(flagSign), longint'(eS));
  endtask

  task automatic applyVec(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op,
                          input logic [1:0] sz, input logic ci, input string extra);
    @(posedge clk);
    opA = a; opB = b; opSel = op; opSize = sz; carryIn = ci;
    @(negedge clk);
    compareNow(extra);
  endtask

  // Directed corners swept over all codes and widths
  task automatic sweepCorners();
    logic [31:0] pats [8];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h0000_007F;
    pats[3] = 32'h0000_7FFF; pats[4] = 32'h7FFF_FFFF; pats[5] = 32'h8000_8080;
    pats[6] = 32'h0000_000F; pats[7] = 32'h1234_0001;
    for (int op = 0; op < 8; op++)
      for (int sz = 0; sz < 4; sz++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j += 3)
            applyVec(pats[i], pats[j], 3'(op), 2'(sz), 1'(i + j), "corner");
  endtask

  // R10: size code 3 must match code 2 at the ports; R11: code 7 matches code 4
  task automatic aliasChecks();
    logic [31:0] r2, r3;
    logic [5:0]  f2, f3;
    for (int k = 0; k < 20; k++) begin
      rngState = nextRand(rngState);
      applyVec(rngState, ~rngState ^ 32'h0F0F_0001, 3'(k % 4), 2'd2, 1'(k), "R10 ref");
      r2 = result; f2 = {flagCarry, flagParity, flagAux, flagZero, flagSign, flagOverflow};
      applyVec(opA, opB, opSel, 2'd3, carryIn, "R10 alias");
      r3 = result; f3 = {flagCarry, flagParity, flagAux, flagZero, flagSign, flagOverflow};
      check("R10 size3 result", longint'(r3), longint'(r2));
      check("R10 size3 flags", longint'(f3), longint'(f2));
      applyVec(rngState, nextRand(rngState), 3'd4, 2'(k % 3), 1'b1, "R11 ref");
      r2 = result; f2 = {flagCarry, flagParity, flagAux, flagZero, flagSign, flagOverflow};
      applyVec(opA, opB, 3'd7, opSize, carryIn, "R11 alias");
      r3 = result; f3 = {flagCarry, flagParity, flagAux, flagZero, flagSign, flagOverflow};
      check("R11 code7 result", longint'(r3), longint'(r2));
      check("R11 code7 flags", longint'(f3), longint'(f2));
    end
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 100000) begin
      failCount++;
      $display("FAIL watchdog expired after %0d cycles (expected completion)", cycleCount);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // idle inputs: all zero add, byte width
    check("R6 idle zero", longint'(flagZero), 1);
    check("R5 idle parity", longint'(flagParity), 1);
    check("R2 idle carry", longint'(flagCarry), 0);
    // specific edge values
    applyVec(32'h0000_00FF, 32'h0000_0001, 3'd0, 2'd0, 1'b0, "R2 byte wrap");
    applyVec(32'h0000_007F, 32'h0000_0000, 3'd1, 2'd0, 1'b1, "R9 R3 adc overflow");
    applyVec(32'h0000_0000, 32'h0000_0000, 3'd3, 2'd1, 1'b1, "R9 sbb borrow");
    applyVec(32'h0000_0010, 32'h0000_0001, 3'd2, 2'd2, 1'b0, "R4 nibble borrow");
    applyVec(32'h0000_000F, 32'h0000_0000, 3'd0, 2'd2, 1'b1, "R9 add ignores cin");
    applyVec(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd6, 2'd2, 1'b1, "R8 xor zero");
    sweepCorners();
    aliasChecks();
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] ra, rb;
      rngState = nextRand(rngState); ra = rngState;
      rngState = nextRand(rngState); rb = rngState;
      applyVec(ra, rb, 3'(n % 8), 2'((n / 8) % 4), rb[17], "random");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end
endmodule